// File: doc/BRIEF.md
# Daisy-Chain Interrupt and Bus Controller for a Four-Channel Counter/Timer

This block is the shared front end of a four-channel counter/timer. It watches the processor's I/O request, chip enable, read and first-machine-cycle strobes together with a two-bit channel code. From these it classifies each bus cycle as a register write, a counter read or an interrupt acknowledge. Writes go out to the channels as one-clock strobes, except for the one write form that loads the shared interrupt base vector, which is kept here. Reads put the chosen channel's live down-counter value on the data bus.

Each channel reports a terminal-count pulse and its interrupt-enable bit. An enabled pulse leaves a pending request, and any pending request pulls the active-low interrupt line. On acknowledge, the highest-ranked eligible channel wins. Channel 0 ranks highest and channel 3 lowest. The winner puts its vector on the bus, its request clears and it becomes in-service. The chain input and chain output tie the block into an external priority chain. An end-of-service pulse retires the highest-ranked in-service channel. The bidirectional bus is split into data-in, data-out and an output enable.

Top module: `daisy_irq_ctl`

## Requirements
- R1: A write cycle (`ioreq_n`=0, `sel_n`=0, `rd_n`=1, `mcyc1_n`=1) raises `wr_stb[chan_sel]` for exactly the first clock of the cycle, with `wr_data` equal to `bus_din`; all other strobe bits stay low.
- R2: A write to channel 0 whose data bit 0 is 0 loads the base vector (bits 7:3 kept) and raises no write strobe.
- R3: A read cycle (`ioreq_n`=0, `sel_n`=0, `rd_n`=0, `mcyc1_n`=1) drives `bus_oe`=1 and `bus_dout` = the `cnt_val` byte of channel `chan_sel` (channel n at bits 8n+7:8n) in the same clock.
- R4: A `tc_pulse` bit with its `irq_en` bit set makes the channel pending one clock later. `irq_n` is 0 while any channel is pending. Clearing `irq_en` drops that channel's pending request.
- R5: On acknowledge (`ioreq_n`=0, `mcyc1_n`=0), the lowest-numbered eligible pending channel wins. From the second clock of the acknowledge until it ends, the block drives `bus_dout` = {base[7:3], channel[1:0], 0} with `bus_oe`=1.
- R6: The winning channel's pending request clears and its in-service flag sets. `irq_n` returns high when nothing else is pending.
- R7: `chain_out` is 1 only when `chain_in` is 1 and no channel is in service.
- R8: With `chain_in`=0, an acknowledge selects no channel, drives no vector and leaves all pending and in-service state unchanged.
- R9: A channel is eligible only if neither it nor any higher-ranked channel is in service, so a higher-ranked channel can nest over a lower-ranked one but not the reverse.
- R10: A one-clock `svc_done` pulse clears the in-service flag of the highest-ranked in-service channel only.
- R11: While `rst_n` is low, `bus_oe` is 0. After reset, `irq_n` is 1 and `chain_out` equals `chain_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_n | input | 1 | Chip enable, active low |
| rd_n | input | 1 | Read strobe, active low |
| ioreq_n | input | 1 | I/O request, active low |
| mcyc1_n | input | 1 | First machine cycle, active low |
| chan_sel | input | 2 | Channel code for reads and writes |
| bus_din | input | 8 | Data bus, inbound half |
| bus_dout | output | 8 | Data bus, outbound half |
| bus_oe | output | 1 | Output enable of the data bus |
| cnt_val | input | 32 | Down-counter values, channel n at bits 8n+7:8n |
| tc_pulse | input | 4 | Terminal-count pulse per channel |
| irq_en | input | 4 | Interrupt enable per channel |
| svc_done | input | 1 | End-of-service pulse |
| chain_in | input | 1 | Priority chain enable from higher-priority devices |
| chain_out | output | 1 | Priority chain enable to lower-priority devices |
| irq_n | output | 1 | Interrupt request, active low, open-drain behaviour |
| wr_stb | output | 4 | One-clock write strobe per channel |
| wr_data | output | 8 | Write data to channels |

## Verification
The acknowledge path is exercised with several request patterns. A single pending channel confirms vector encoding. Two channels made pending in the same clock show that rank, not arrival order, decides the winner. A lower channel pending while a higher one is in service must be refused. A higher channel arriving while a lower one is in service must nest, which separates "blocked by a higher service" from "blocked by any service". Acknowledges with the chain input low, and end-of-service pulses with two channels in service, show that only the top in-service flag retires and that a blocked device changes no state. Writes are tried with vector and non-vector data on channel 0, so that a plain strobe can be told apart from a vector load.

// File: rtl/daisy_irq_pkg.sv
// Package: shared cycle classification for the interrupt/bus controller.
// Assumes strobes are already synchronous to clk.
package daisy_irq_pkg;
    typedef enum logic [1:0] {
        CYC_IDLE = 2'd0,
        CYC_WR   = 2'd1,
        CYC_RD   = 2'd2,
        CYC_ACK  = 2'd3
    } cyc_kind_t;
endpackage

// File: rtl/bus_cycle_decode.sv
// Module: classifies the current bus cycle from the processor strobes and
// flags the first clock of writes and acknowledges.
// Assumes a cycle holds its strobes for at least two clocks.
module bus_cycle_decode
    import daisy_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sel_n,
    input  logic      rd_n,
    input  logic      ioreq_n,
    input  logic      mcyc1_n,
    output cyc_kind_t cyc,
    output logic      wr_start,
    output logic      ack_start,
    output logic      ack_active
);
    cyc_kind_t prev_q;

    // Classify: acknowledge outranks chip-enabled accesses.
    always_comb begin
        if (!ioreq_n && !mcyc1_n)     cyc = CYC_ACK;
        else if (!ioreq_n && !sel_n)  cyc = rd_n ? CYC_WR : CYC_RD;
        else                          cyc = CYC_IDLE;
    end

    // Remember last cycle kind to find cycle starts.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= CYC_IDLE;
        else        prev_q <= cyc;
    end

    assign wr_start   = (cyc == CYC_WR)  && (prev_q != CYC_WR);
    assign ack_start  = (cyc == CYC_ACK) && (prev_q != CYC_ACK);
    assign ack_active = (cyc == CYC_ACK);

    // R1: a write strobe lasts a single clock
    assert_wr_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |=> !wr_start);
endmodule

// File: rtl/irq_prio_core.sv
// Module: pending and in-service tracking with fixed priority (index 0
// highest), chain gating, winner selection and end-of-service retirement.
// Assumes tc_pulse bits are single-clock pulses.
module irq_prio_core #(
    parameter int NCH = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NCH-1:0]           tc_pulse,
    input  logic [NCH-1:0]           irq_en,
    input  logic                     chain_in,
    input  logic                     ack_start,
    input  logic                     ack_active,
    input  logic                     svc_done,
    output logic                     chain_out,
    output logic                     irq_n,
    output logic                     ack_own,
    output logic [$clog2(NCH)-1:0]   ack_ch
);
    localparam int CW = $clog2(NCH);

    logic [NCH-1:0] ip_q, ius_q, above, elig, grant_mask, eos_mask;
    logic [CW-1:0]  win_idx;
    logic           win_vld, grant;

    // Service blocking: OR of in-service flags at this rank and above.
    genvar g;
    generate
        for (g = 0; g < NCH; g++) begin : g_blk
            if (g == 0) begin : g_top
                assign above[g] = ius_q[g];
            end else begin : g_rest
                assign above[g] = above[g-1] | ius_q[g];
            end
            assign elig[g] = chain_in & ip_q[g] & ~above[g];
        end
    endgenerate

    // Priority encoder: lowest index among eligible channels.
    always_comb begin
        win_vld = 1'b0;
        win_idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (elig[i]) begin
                win_vld = 1'b1;
                win_idx = CW'(i);
            end
        end
    end

    assign grant      = ack_start & win_vld;
    assign grant_mask = grant ? (NCH'(1) << win_idx) : '0;
    assign eos_mask   = svc_done ? (ius_q & (~ius_q + NCH'(1))) : '0;

    // Update pending and in-service flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ip_q  <= '0;
            ius_q <= '0;
        end else begin
            ip_q  <= ((ip_q & ~grant_mask) | (tc_pulse & irq_en)) & irq_en;
            ius_q <= (ius_q & ~eos_mask) | grant_mask;
        end
    end

    // Hold the acknowledged channel for the rest of the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_own <= 1'b0;
            ack_ch  <= '0;
        end else if (grant) begin
            ack_own <= 1'b1;
            ack_ch  <= win_idx;
        end else if (!ack_active) begin
            ack_own <= 1'b0;
        end
    end

    assign chain_out = chain_in & ~(|ius_q);
    assign irq_n     = ~(|ip_q);

    // R6: a granted channel is in service on the next clock
    assert_grant_sets_ius_R6: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> ius_q[$past(win_idx)]);
    // R8: no grant without the chain enable
    assert_grant_needs_chain_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_start && !chain_in |=> !ack_own);
    // R10: end of service retires exactly one flag
    assert_eos_one_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_done && (|ius_q) && !grant) |=>
            ($countones(ius_q) + 1 == $past($countones(ius_q))));
endmodule

// File: rtl/bus_drive_mux.sv
// Module: base-vector register, write-strobe fan-out and data-bus output
// selection (counter read or acknowledge vector).
// Assumes the vector layout {base, channel, 0}.
module bus_drive_mux
    import daisy_irq_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  cyc_kind_t              cyc,
    input  logic                   wr_start,
    input  logic [$clog2(NCH)-1:0] chan_sel,
    input  logic [DW-1:0]          bus_din,
    input  logic [NCH*DW-1:0]      cnt_val,
    input  logic                   ack_own,
    input  logic [$clog2(NCH)-1:0] ack_ch,
    output logic [DW-1:0]          bus_dout,
    output logic                   bus_oe,
    output logic [NCH-1:0]         wr_stb,
    output logic [DW-1:0]          wr_data
);
    localparam int CW = $clog2(NCH);
    localparam int BW = DW - CW - 1;

    logic [BW-1:0] base_q;
    logic          vec_wr;

    assign vec_wr = wr_start && (chan_sel == '0) && !bus_din[0];

    // Load the base vector on a vector-form write.
    always_ff @(posedge clk) begin
        if (!rst_n)      base_q <= '0;
        else if (vec_wr) base_q <= bus_din[DW-1:CW+1];
    end

    // One strobe line per channel.
    genvar g;
    generate
        for (g = 0; g < NCH; g++) begin : g_stb
            assign wr_stb[g] = wr_start && !vec_wr && (chan_sel == CW'(g));
        end
    endgenerate
    assign wr_data = bus_din;

    // Select outbound data and enable.
    always_comb begin
        if (ack_own) bus_dout = {base_q, ack_ch, 1'b0};
        else         bus_dout = cnt_val[chan_sel*DW +: DW];
        bus_oe = rst_n && ((cyc == CYC_RD) || (ack_own && cyc == CYC_ACK));
    end

    // R2: vector-form write lands in the base register
    assert_vec_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        vec_wr |=> base_q == $past(bus_din[DW-1:CW+1]));
    // R3: a read cycle always drives the bus
    assert_read_drives_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == CYC_RD) |-> bus_oe);
endmodule

// File: rtl/daisy_irq_ctl.sv
// Module: top of the interrupt/bus controller for a four-channel
// counter/timer; wires decode, priority core and bus mux together.
// Assumes synchronous strobes and a synchronous active-low reset.
module daisy_irq_ctl
    import daisy_irq_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sel_n,
    input  logic                   rd_n,
    input  logic                   ioreq_n,
    input  logic                   mcyc1_n,
    input  logic [$clog2(NCH)-1:0] chan_sel,
    input  logic [DW-1:0]          bus_din,
    output logic [DW-1:0]          bus_dout,
    output logic                   bus_oe,
    input  logic [NCH*DW-1:0]      cnt_val,
    input  logic [NCH-1:0]         tc_pulse,
    input  logic [NCH-1:0]         irq_en,
    input  logic                   svc_done,
    input  logic                   chain_in,
    output logic                   chain_out,
    output logic                   irq_n,
    output logic [NCH-1:0]         wr_stb,
    output logic [DW-1:0]          wr_data
);
    localparam int CW = $clog2(NCH);

    cyc_kind_t     cyc;
    logic          wr_start, ack_start, ack_active, ack_own;
    logic [CW-1:0] ack_ch;

    bus_cycle_decode u_dec (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rd_n(rd_n),
        .ioreq_n(ioreq_n), .mcyc1_n(mcyc1_n), .cyc(cyc),
        .wr_start(wr_start), .ack_start(ack_start), .ack_active(ack_active)
    );

    irq_prio_core #(.NCH(NCH)) u_core (
        .clk(clk), .rst_n(rst_n), .tc_pulse(tc_pulse), .irq_en(irq_en),
        .chain_in(chain_in), .ack_start(ack_start), .ack_active(ack_active),
        .svc_done(svc_done), .chain_out(chain_out), .irq_n(irq_n),
        .ack_own(ack_own), .ack_ch(ack_ch)
    );

    bus_drive_mux #(.NCH(NCH), .DW(DW)) u_mux (
        .clk(clk), .rst_n(rst_n), .cyc(cyc), .wr_start(wr_start),
        .chan_sel(chan_sel), .bus_din(bus_din), .cnt_val(cnt_val),
        .ack_own(ack_own), .ack_ch(ack_ch), .bus_dout(bus_dout),
        .bus_oe(bus_oe), .wr_stb(wr_stb), .wr_data(wr_data)
    );

    // R5: vector drive only inside an acknowledge the block won
    assert_vec_in_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && mcyc1_n == 1'b0) |-> ack_own);
endmodule

// File: tb/tb_daisy_irq_ctl.sv
module tb_daisy_irq_ctl;
    logic        clk = 1'b0;
    logic        rst_n, sel_n, rd_n, ioreq_n, mcyc1_n, svc_done, chain_in;
    logic [1:0]  chan_sel;
    logic [7:0]  bus_din, bus_dout, wr_data;
    logic        bus_oe, chain_out, irq_n;
    logic [31:0] cnt_val;
    logic [3:0]  tc_pulse, irq_en, wr_stb;

    int total = 0;
    int bad   = 0;
    logic [7:0] exp_q[$];
    logic       oe_prev = 1'b0;

    always #2 clk = ~clk;

    daisy_irq_ctl dut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rd_n(rd_n),
        .ioreq_n(ioreq_n), .mcyc1_n(mcyc1_n), .chan_sel(chan_sel),
        .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe),
        .cnt_val(cnt_val), .tc_pulse(tc_pulse), .irq_en(irq_en),
        .svc_done(svc_done), .chain_in(chain_in), .chain_out(chain_out),
        .irq_n(irq_n), .wr_stb(wr_stb), .wr_data(wr_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: each new bus drive pops one expected byte.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && bus_oe === 1'b1 && !oe_prev) begin
            if (exp_q.size() == 0) chk("R5 unexpected drive", {24'd0, bus_dout}, 32'hFFFF);
            else chk("R3/R5 bus data", {24'd0, bus_dout}, {24'd0, exp_q.pop_front()});
        end
        oe_prev = (bus_oe === 1'b1);
    end

    task automatic idle_bus();
        sel_n = 1; rd_n = 1; ioreq_n = 1; mcyc1_n = 1;
    endtask

    task automatic do_write(input logic [1:0] ch, input logic [7:0] d, input logic [3:0] exp_stb, input string req);
        @(posedge clk); #1;
        ioreq_n = 0; sel_n = 0; rd_n = 1; chan_sel = ch; bus_din = d;
        @(negedge clk);
        chk(req, {28'd0, wr_stb}, {28'd0, exp_stb});
        if (exp_stb != 0) chk({req, " data"}, {24'd0, wr_data}, {24'd0, d});
        @(negedge clk);
        chk({req, " single"}, {28'd0, wr_stb}, 32'd0);
        @(posedge clk); #1; idle_bus();
    endtask

    task automatic do_read(input logic [1:0] ch, input logic [7:0] exp);
        @(posedge clk); #1;
        exp_q.push_back(exp);
        ioreq_n = 0; sel_n = 0; rd_n = 0; chan_sel = ch;
        @(negedge clk);
        chk("R3 oe", {31'd0, bus_oe}, 32'd1);
        @(posedge clk); #1; idle_bus();
    endtask

    task automatic do_ack(input logic vld, input logic [7:0] vec, input string req);
        @(posedge clk); #1;
        if (vld) exp_q.push_back(vec);
        ioreq_n = 0; mcyc1_n = 0;
        @(negedge clk);
        chk({req, " first clock quiet"}, {31'd0, bus_oe}, 32'd0);
        repeat (2) @(negedge clk);
        chk({req, " oe"}, {31'd0, bus_oe}, {31'd0, vld});
        @(posedge clk); #1; idle_bus();
        @(posedge clk); #1;
    endtask

    task automatic pulse_tc(input logic [3:0] m);
        @(posedge clk); #1; tc_pulse = m;
        @(posedge clk); #1; tc_pulse = 0;
    endtask

    task automatic pulse_eos();
        @(posedge clk); #1; svc_done = 1;
        @(posedge clk); #1; svc_done = 0;
    endtask

    initial begin
        #(4 * 150000);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 0; idle_bus(); chan_sel = 0; bus_din = 0; svc_done = 0;
        chain_in = 1; tc_pulse = 0; irq_en = 0;
        cnt_val = {8'h44, 8'h33, 8'h22, 8'h11};
        repeat (2) @(posedge clk);
        #1; ioreq_n = 0; sel_n = 0; rd_n = 0;
        @(negedge clk);
        chk("R11 oe in reset", {31'd0, bus_oe}, 32'd0);
        idle_bus();
        @(posedge clk); #1; rst_n = 1;
        @(negedge clk);
        chk("R11 irq_n", {31'd0, irq_n}, 32'd1);
        chk("R11 chain_out", {31'd0, chain_out}, 32'd1);

        // R2: vector write, no strobe; R1: ordinary writes
        do_write(2'd0, 8'hA8, 4'b0000, "R2 vector write");
        do_write(2'd2, 8'h57, 4'b0100, "R1 write ch2");
        do_write(2'd0, 8'h03, 4'b0001, "R1 write ch0 control");

        // R3 reads
        do_read(2'd1, 8'h22);
        do_read(2'd3, 8'h44);

        // R4 pending
        irq_en = 4'hF;
        pulse_tc(4'b1010);
        @(negedge clk);
        chk("R4 irq_n low", {31'd0, irq_n}, 32'd0);

        // R5/R6 ch1 wins, ch3 still pending
        do_ack(1, 8'hAA, "R5 ack ch1");
        @(negedge clk);
        chk("R7 chain_out with service", {31'd0, chain_out}, 32'd0);
        chk("R6 irq_n still low", {31'd0, irq_n}, 32'd0);

        // R9: ch3 blocked behind ch1
        do_ack(0, 8'h00, "R9 lower blocked");
        // R9: ch0 nests
        pulse_tc(4'b0001);
        do_ack(1, 8'hA8, "R9 higher nests");

        // R10: first retire clears ch0 only, ch3 still blocked
        pulse_eos();
        do_ack(0, 8'h00, "R10 ch1 still in service");
        pulse_eos();
        @(negedge clk);
        chk("R10 chain_out after all retired", {31'd0, chain_out}, 32'd1);
        do_ack(1, 8'hAE, "R5 ack ch3");
        @(negedge clk);
        chk("R6 irq_n released", {31'd0, irq_n}, 32'd1);
        pulse_eos();

        // R8: chain blocked
        chain_in = 0;
        pulse_tc(4'b0100);
        @(negedge clk);
        chk("R7 chain_out follows chain_in", {31'd0, chain_out}, 32'd0);
        do_ack(0, 8'h00, "R8 chain low");
        @(negedge clk);
        chk("R8 pending kept", {31'd0, irq_n}, 32'd0);
        chain_in = 1;
        @(negedge clk);
        chk("R8 no service taken", {31'd0, chain_out}, 32'd1);
        do_ack(1, 8'hAC, "R8 ack after chain high");
        pulse_eos();

        // R4: disabling clears pending
        pulse_tc(4'b0001);
        @(negedge clk);
        chk("R4 pending ch0", {31'd0, irq_n}, 32'd0);
        #1; irq_en = 4'b1110;
        @(negedge clk);
        chk("R4 disable clears", {31'd0, irq_n}, 32'd1);
        irq_en = 4'hF;

        // R5: simultaneous requests resolved by rank
        pulse_tc(4'b0110);
        do_ack(1, 8'hAA, "R5 rank ch1 over ch2");
        pulse_eos();
        do_ack(1, 8'hAC, "R5 then ch2");
        pulse_eos();

        repeat (2) @(negedge clk);
        chk("R5 scoreboard drained", exp_q.size(), 32'd0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule